// File: doc/BRIEF.md
# Power-Management Configuration I/O Window Decoder

This block is the configuration-register slice of a power-management function. It keeps two I/O base registers and their enable bits, plus the device-specific configuration bytes above the standard header. From an incoming I/O address it produces two decode hits. The first is a 128-byte power-management window. The second is a 16-byte window for the secondary bus controller.

Configuration writes arrive as a 32-bit data word with four byte-lane enables, addressed by dword index. Each base register aligns itself on every write that touches it. Bits below its alignment are cleared, the upper half-word is cleared, and bit 0 is forced to 1 to mark I/O space. Each window decodes only while its enable bit is set. Configuration reads are combinational and return what is stored. The standard header region is not held here and reads as zero.

Top module: `pmw_cfg_window`

## Requirements
- R1: After reset, both base registers read 0x00000001, every byte in the extension area (offsets 0x40 and up) reads zero, and neither hit output is high.
- R2: A write that touches the power-management base dword (byte offset 0x48) stores (merged value AND 0x0000FF80) OR 1.
- R3: A write that touches the secondary base dword (byte offset 0x90) stores (merged value AND 0x0000FFF0) OR 1.
- R4: A configuration write updates only the byte lanes whose enable bit is set. Lane n carries data bits [8n+7:8n] for byte offset 4*index+n. Unselected bytes keep their value.
- R5: The power-management window is enabled by bit 7 of byte 0x41 (dword index 0x10, lane 1). While that bit is clear, pm_hit stays low.
- R6: The secondary window is enabled by bit 0 of byte 0xD2 (dword index 0x34, lane 2). Any write to that byte keeps only its low four bits.
- R7: pm_hit is high exactly when io_req and io_byte are high, the window is enabled, and io_addr[15:7] equals base[15:7].
- R8: aux_hit is high exactly when io_req is high, the window is enabled, and io_addr[15:4] equals base[15:4]. The access size does not matter.
- R9: Writes to dword indices below 0x10 (the 64-byte header) have no effect, and reads there return zero.
- R10: io_rd_data is zero whenever pm_hit is high, because the window reads back as zero.
- R11: A base write that selects only some lanes merges those lanes into the current value before masking. Lanes 2 and 3 therefore can never make the upper half-word nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_dw | input | 6 | Dword index of the write |
| cfg_wr_be | input | 4 | Byte-lane enables of the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_dw | input | 6 | Dword index of the read |
| cfg_rd_data | output | 32 | Read data (combinational) |
| io_req | input | 1 | I/O access present |
| io_byte | input | 1 | The access is a single byte |
| io_addr | input | 16 | I/O address |
| pm_hit | output | 1 | Power-management window claims the access |
| aux_hit | output | 1 | Secondary window claims the access |
| io_rd_data | output | 8 | Read data for the power-management window |

## Verification
The bench builds the block with its default parameters. These are a 256-byte space with a 64-byte header, 128-byte and 16-byte alignment, and a 16-bit I/O address. With these values, both window edges (first and last byte, and one byte outside each side) can be reached with a few directed addresses. The bench also covers partial-lane writes that straddle the masked base bits, and the enable byte whose upper nibble is discarded.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

    // Per-byte write mask for the generic extension bytes.
    // Bytes that belong to a base dword are held elsewhere (mask 0).
    function automatic logic [7:0] byte_keep(
        input int off,
        input int pm_base_off,
        input int aux_base_off,
        input int aux_en_off,
        input logic [7:0] aux_en_keep
    );
        if ((off / 4) == (pm_base_off / 4) || (off / 4) == (aux_base_off / 4))
            return 8'h00;
        if (off == aux_en_off)
            return aux_en_keep;
        return 8'hFF;
    endfunction

    // Mask keeping bits [aw-1:align] of a 32-bit word.
    function automatic logic [31:0] base_mask(input int aw, input int align);
        logic [31:0] m;
        for (int b = 0; b < 32; b++)
            m[b] = (b >= align) && (b < aw);
        return m;
    endfunction

    // Merge a byte-enabled write into an old word.
    function automatic logic [31:0] lane_merge(
        input logic [31:0] old_v,
        input logic [31:0] new_v,
        input logic [3:0]  be
    );
        logic [31:0] r;
        for (int l = 0; l < 4; l++)
            r[8*l +: 8] = be[l] ? new_v[8*l +: 8] : old_v[8*l +: 8];
        return r;
    endfunction

endpackage

// File: rtl/pmw_byte_bank.sv
module pmw_byte_bank #(
    parameter int CFG_BYTES    = 256,
    parameter int HDR_BYTES    = 64,
    parameter int PM_BASE_OFF  = 'h48,
    parameter int AUX_BASE_OFF = 'h90,
    parameter int AUX_EN_OFF   = 'hD2,
    parameter logic [7:0] AUX_EN_KEEP = 8'h0F,
    localparam int DWW = $clog2(CFG_BYTES) - 2,
    localparam int EXT = CFG_BYTES - HDR_BYTES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [DWW-1:0]       wr_dw,
    input  logic [3:0]           wr_be,
    input  logic [31:0]          wr_data,
    output logic [EXT-1:0][7:0]  bytes_o
);
    for (genvar i = 0; i < EXT; i++) begin : g_byte
        localparam int OFF  = HDR_BYTES + i;
        localparam int LANE = OFF % 4;
        localparam logic [DWW-1:0] DW = DWW'(OFF / 4);
        localparam logic [7:0] KEEP = pmw_pkg::byte_keep(
            OFF, PM_BASE_OFF, AUX_BASE_OFF, AUX_EN_OFF, AUX_EN_KEEP);
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 8'h00;
            else if (wr_en && wr_dw == DW && wr_be[LANE])
                q <= wr_data[8*LANE +: 8] & KEEP;
        end
        assign bytes_o[i] = q;
    end
endmodule

// File: rtl/pmw_base_reg.sv
module pmw_base_reg #(
    parameter int CFG_BYTES = 256,
    parameter int BASE_OFF  = 'h48,
    parameter int IO_AW     = 16,
    parameter int ALIGN     = 7,
    localparam int DWW = $clog2(CFG_BYTES) - 2,
    localparam logic [DWW-1:0] DW = DWW'(BASE_OFF / 4),
    localparam logic [31:0] MASK = pmw_pkg::base_mask(IO_AW, ALIGN)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [DWW-1:0] wr_dw,
    input  logic [3:0]     wr_be,
    input  logic [31:0]    wr_data,
    output logic [31:0]    base_o
);
    logic [31:0] q;
    logic [31:0] merged;

    assign merged = pmw_pkg::lane_merge(q, wr_data, wr_be);

    always_ff @(posedge clk) begin
        if (rst)
            q <= 32'h0000_0001;
        else if (wr_en && wr_dw == DW && wr_be != 4'b0000)
            q <= (merged & MASK) | 32'h1;
    end

    assign base_o = q;
endmodule

// File: rtl/pmw_window_dec.sv
module pmw_window_dec #(
    parameter int IO_AW = 16,
    parameter int ALIGN = 7,
    parameter bit NEED_BYTE = 1'b1
) (
    input  logic             req,
    input  logic             is_byte,
    input  logic             enable,
    input  logic [IO_AW-1:0] addr,
    input  logic [IO_AW-1:0] base,
    output logic             hit
);
    logic [IO_AW-1:0] diff;
    logic             size_ok;

    assign diff = (addr ^ base) >> ALIGN;

    if (NEED_BYTE) begin : g_sz
        assign size_ok = is_byte;
    end else begin : g_any
        assign size_ok = 1'b1 | is_byte;
    end

    assign hit = req && enable && size_ok && (diff == '0);
endmodule

// File: rtl/pmw_cfg_window.sv
module pmw_cfg_window #(
    parameter int CFG_BYTES    = 256,
    parameter int HDR_BYTES    = 64,
    parameter int IO_AW        = 16,
    parameter int PM_BASE_OFF  = 'h48,
    parameter int PM_ALIGN     = 7,
    parameter int PM_EN_OFF    = 'h41,
    parameter int PM_EN_BIT    = 7,
    parameter int AUX_BASE_OFF = 'h90,
    parameter int AUX_ALIGN    = 4,
    parameter int AUX_EN_OFF   = 'hD2,
    parameter int AUX_EN_BIT   = 0,
    parameter logic [7:0] AUX_EN_KEEP = 8'h0F,
    localparam int DWW = $clog2(CFG_BYTES) - 2,
    localparam int EXT = CFG_BYTES - HDR_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [DWW-1:0]   cfg_wr_dw,
    input  logic [3:0]       cfg_wr_be,
    input  logic [31:0]      cfg_wr_data,
    input  logic [DWW-1:0]   cfg_rd_dw,
    output logic [31:0]      cfg_rd_data,
    input  logic             io_req,
    input  logic             io_byte,
    input  logic [IO_AW-1:0] io_addr,
    output logic             pm_hit,
    output logic             aux_hit,
    output logic [7:0]       io_rd_data
);
    localparam logic [DWW-1:0] PM_DW  = DWW'(PM_BASE_OFF / 4);
    localparam logic [DWW-1:0] AUX_DW = DWW'(AUX_BASE_OFF / 4);
    localparam int HDR_DW = HDR_BYTES / 4;

    logic [EXT-1:0][7:0] ext_bytes;
    logic [31:0]         pm_base_q;
    logic [31:0]         aux_base_q;
    logic                pm_en;
    logic                aux_en;
    logic [7:0]          aux_en_byte;

    pmw_byte_bank #(
        .CFG_BYTES(CFG_BYTES), .HDR_BYTES(HDR_BYTES),
        .PM_BASE_OFF(PM_BASE_OFF), .AUX_BASE_OFF(AUX_BASE_OFF),
        .AUX_EN_OFF(AUX_EN_OFF), .AUX_EN_KEEP(AUX_EN_KEEP)
    ) bank_i (
        .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_dw(cfg_wr_dw),
        .wr_be(cfg_wr_be), .wr_data(cfg_wr_data), .bytes_o(ext_bytes)
    );

    pmw_base_reg #(
        .CFG_BYTES(CFG_BYTES), .BASE_OFF(PM_BASE_OFF),
        .IO_AW(IO_AW), .ALIGN(PM_ALIGN)
    ) pm_base_i (
        .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_dw(cfg_wr_dw),
        .wr_be(cfg_wr_be), .wr_data(cfg_wr_data), .base_o(pm_base_q)
    );

    pmw_base_reg #(
        .CFG_BYTES(CFG_BYTES), .BASE_OFF(AUX_BASE_OFF),
        .IO_AW(IO_AW), .ALIGN(AUX_ALIGN)
    ) aux_base_i (
        .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_dw(cfg_wr_dw),
        .wr_be(cfg_wr_be), .wr_data(cfg_wr_data), .base_o(aux_base_q)
    );

    assign pm_en       = ext_bytes[PM_EN_OFF - HDR_BYTES][PM_EN_BIT];
    assign aux_en_byte = ext_bytes[AUX_EN_OFF - HDR_BYTES];
    assign aux_en      = aux_en_byte[AUX_EN_BIT];

    pmw_window_dec #(.IO_AW(IO_AW), .ALIGN(PM_ALIGN), .NEED_BYTE(1'b1)) pm_dec_i (
        .req(io_req), .is_byte(io_byte), .enable(pm_en), .addr(io_addr),
        .base(pm_base_q[IO_AW-1:0]), .hit(pm_hit)
    );

    pmw_window_dec #(.IO_AW(IO_AW), .ALIGN(AUX_ALIGN), .NEED_BYTE(1'b0)) aux_dec_i (
        .req(io_req), .is_byte(io_byte), .enable(aux_en), .addr(io_addr),
        .base(aux_base_q[IO_AW-1:0]), .hit(aux_hit)
    );

    // The power-management window holds no registers of its own here.
    assign io_rd_data = 8'h00;

    always_comb begin
        cfg_rd_data = 32'h0;
        if (cfg_rd_dw == PM_DW) begin
            cfg_rd_data = pm_base_q;
        end else if (cfg_rd_dw == AUX_DW) begin
            cfg_rd_data = aux_base_q;
        end else if (int'(cfg_rd_dw) >= HDR_DW) begin
            for (int l = 0; l < 4; l++)
                cfg_rd_data[8*l +: 8] = ext_bytes[int'(cfg_rd_dw) * 4 + l - HDR_BYTES];
        end
    end
endmodule

// File: rtl/pmw_cfg_window_chk.sv
module pmw_cfg_window_chk #(
    parameter int DWW   = 6,
    parameter int IO_AW = 16,
    parameter int HDR_DW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [DWW-1:0]   cfg_rd_dw,
    input logic [31:0]      cfg_rd_data,
    input logic             io_req,
    input logic             io_byte,
    input logic             pm_hit,
    input logic             aux_hit,
    input logic [7:0]       io_rd_data,
    input logic             pm_en,
    input logic             aux_en,
    input logic [7:0]       aux_en_byte,
    input logic [31:0]      pm_base_q,
    input logic [31:0]      aux_base_q
);
    a_r1_reset_clears_enables: assert property (@(posedge clk)
        rst |=> (!pm_en && !aux_en && pm_base_q == 32'h1 && aux_base_q == 32'h1));

    a_r2_pm_base_form: assert property (@(posedge clk) disable iff (rst)
        pm_base_q[6:0] == 7'h01 && pm_base_q[31:16] == 16'h0);

    a_r3_aux_base_form: assert property (@(posedge clk) disable iff (rst)
        aux_base_q[3:0] == 4'h1 && aux_base_q[31:16] == 16'h0);

    a_r6_aux_en_nibble: assert property (@(posedge clk) disable iff (rst)
        aux_en_byte[7:4] == 4'h0);

    a_r7_pm_hit_qualified: assert property (@(posedge clk) disable iff (rst)
        pm_hit |-> (pm_en && io_byte && io_req));

    a_r8_aux_hit_qualified: assert property (@(posedge clk) disable iff (rst)
        aux_hit |-> (aux_en && io_req));

    a_r9_header_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (int'(cfg_rd_dw) < HDR_DW) |-> cfg_rd_data == 32'h0);

    a_r10_pm_read_zero: assert property (@(posedge clk) disable iff (rst)
        pm_hit |-> io_rd_data == 8'h00);
endmodule

bind pmw_cfg_window pmw_cfg_window_chk #(
    .DWW(DWW), .IO_AW(IO_AW), .HDR_DW(HDR_BYTES / 4)
) chk_i (
    .clk(clk), .rst(rst), .cfg_rd_dw(cfg_rd_dw), .cfg_rd_data(cfg_rd_data),
    .io_req(io_req), .io_byte(io_byte), .pm_hit(pm_hit), .aux_hit(aux_hit),
    .io_rd_data(io_rd_data), .pm_en(pm_en), .aux_en(aux_en),
    .aux_en_byte(aux_en_byte), .pm_base_q(pm_base_q), .aux_base_q(aux_base_q)
);

// File: tb/pmw_cfg_window_tb_top.sv
`timescale 1ns/1ps
module pmw_cfg_window_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [5:0]  cfg_wr_dw = '0;
    logic [3:0]  cfg_wr_be = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [5:0]  cfg_rd_dw = '0;
    logic [31:0] cfg_rd_data;
    logic        io_req = 1'b0;
    logic        io_byte = 1'b0;
    logic [15:0] io_addr = '0;
    logic        pm_hit;
    logic        aux_hit;
    logic [7:0]  io_rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    pmw_cfg_window dut_i (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_dw(cfg_wr_dw),
        .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data), .cfg_rd_dw(cfg_rd_dw),
        .cfg_rd_data(cfg_rd_data), .io_req(io_req), .io_byte(io_byte),
        .io_addr(io_addr), .pm_hit(pm_hit), .aux_hit(aux_hit),
        .io_rd_data(io_rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] off, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_dw = off[7:2]; cfg_wr_be = be; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_be = '0;
    endtask

    task automatic cfg_check(input string req, input logic [7:0] off, input logic [31:0] exp);
        cfg_rd_dw = off[7:2];
        #1;
        check(req, cfg_rd_data, exp);
    endtask

    task automatic io_check(input string req, input logic [15:0] a, input logic bsz,
                            input logic exp_pm, input logic exp_aux);
        io_req = 1'b1; io_byte = bsz; io_addr = a;
        #1;
        check({req, " pm_hit"}, {31'b0, pm_hit}, {31'b0, exp_pm});
        check({req, " aux_hit"}, {31'b0, aux_hit}, {31'b0, exp_aux});
        if (pm_hit) check({req, " R10 io_rd_data"}, {24'b0, io_rd_data}, 32'h0);
        io_req = 1'b0;
    endtask

    task automatic t_reset;
        cfg_check("R1 pm base", 8'h48, 32'h1);
        cfg_check("R1 aux base", 8'h90, 32'h1);
        cfg_check("R1 pm enable dword", 8'h40, 32'h0);
        cfg_check("R1 aux enable dword", 8'hD0, 32'h0);
        cfg_check("R1 ext byte", 8'hFC, 32'h0);
        io_check("R1 idle", 16'h0000, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_bases;
        cfg_write(8'h48, 4'hF, 32'hDEAD_BEEF);
        cfg_check("R2 pm base mask", 8'h48, 32'h0000_BE81);
        cfg_write(8'h90, 4'hF, 32'h1234_5678);
        cfg_check("R3 aux base mask", 8'h90, 32'h0000_5671);
    endtask

    task automatic t_lanes;
        cfg_write(8'h60, 4'b0101, 32'hAABB_CCDD);
        cfg_check("R4 lanes 0,2", 8'h60, 32'h00BB_00DD);
        cfg_write(8'h60, 4'b1010, 32'h1122_3344);
        cfg_check("R4 lanes 1,3", 8'h60, 32'h11BB_33DD);
        cfg_write(8'h64, 4'b0000, 32'hFFFF_FFFF);
        cfg_check("R4 no lanes", 8'h64, 32'h0);
    endtask

    task automatic t_partial_base;
        cfg_write(8'h48, 4'b0010, 32'h0000_1200);
        cfg_check("R11 pm base lane1", 8'h48, 32'h0000_1281);
        cfg_write(8'h48, 4'b1100, 32'hFFFF_FFFF);
        cfg_check("R11 pm base upper lanes", 8'h48, 32'h0000_1281);
        cfg_write(8'h90, 4'b0001, 32'h0000_00FF);
        cfg_check("R11 aux base lane0", 8'h90, 32'h0000_56F1);
        cfg_write(8'h90, 4'b0001, 32'h0000_0070);
        cfg_check("R11 aux base restore", 8'h90, 32'h0000_5671);
    endtask

    task automatic t_pm_window;
        io_check("R5 pm disabled", 16'h12C5, 1'b1, 1'b0, 1'b0);
        cfg_write(8'h40, 4'b0010, 32'h0000_8000);
        cfg_check("R5 enable byte", 8'h40, 32'h0000_8000);
        io_check("R7 inside", 16'h12C5, 1'b1, 1'b1, 1'b0);
        io_check("R7 first", 16'h1280, 1'b1, 1'b1, 1'b0);
        io_check("R7 last", 16'h12FF, 1'b1, 1'b1, 1'b0);
        io_check("R7 below", 16'h127F, 1'b1, 1'b0, 1'b0);
        io_check("R7 above", 16'h1300, 1'b1, 1'b0, 1'b0);
        io_check("R7 wide access", 16'h12C5, 1'b0, 1'b0, 1'b0);
        cfg_write(8'h40, 4'b0010, 32'h0000_7F00);
        io_check("R5 disabled again", 16'h12C5, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_aux_window;
        io_check("R6 aux disabled", 16'h5675, 1'b1, 1'b0, 1'b0);
        cfg_write(8'hD0, 4'b0100, 32'h00FF_0000);
        cfg_check("R6 nibble kept", 8'hD0, 32'h000F_0000);
        io_check("R8 inside", 16'h5675, 1'b0, 1'b0, 1'b1);
        io_check("R8 first", 16'h5670, 1'b1, 1'b0, 1'b1);
        io_check("R8 last", 16'h567F, 1'b1, 1'b0, 1'b1);
        io_check("R8 below", 16'h566F, 1'b1, 1'b0, 1'b0);
        io_check("R8 above", 16'h5680, 1'b1, 1'b0, 1'b0);
        cfg_write(8'hD0, 4'b0100, 32'h00FE_0000);
        cfg_check("R6 cleared", 8'hD0, 32'h000E_0000);
        io_check("R6 aux off", 16'h5675, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_header;
        cfg_write(8'h04, 4'hF, 32'hFFFF_FFFF);
        cfg_check("R9 header 0x04", 8'h04, 32'h0);
        cfg_write(8'h3C, 4'hF, 32'hA5A5_A5A5);
        cfg_check("R9 header 0x3C", 8'h3C, 32'h0);
        cfg_check("R9 ext untouched", 8'h60, 32'h11BB_33DD);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bases();
        t_lanes();
        t_partial_base();
        t_pm_window();
        t_aux_window();
        t_header();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule